// File: doc/BRIEF.md
# Memory Access Wait-State Timer

This block sits beside a memory controller's access sequencer and decides how long each access takes. When the sequencer launches an access it presents the memory type of the selected chip select, the read/write direction, that chip select's 32-bit timing word and a flag that says whether the access goes to the controller's own register bank. The block picks the wait count for that combination, loads it into a down-counter, holds busy while the count runs and raises a single-cycle acknowledge when it finishes.

The wait count is not a single constant. For asynchronous devices it is the sum of several timing-word fields, and which fields are summed depends on the direction. SDRAM adds a small field to a fixed base. Pipelined SRAM, generic synchronous parts, unknown type codes and register-bank accesses all use a fixed two cycles. No refresh cycles are generated or accounted for.

Top module: `access_wait_timer`

## Requirements
- R1: With mem_type_i = 2 (asynchronous) and we_i = 0, the latency L is timing_i[7:0] + timing_i[11:8].
- R2: With mem_type_i = 2 and we_i = 1, L is timing_i[15:12] + timing_i[19:16] + timing_i[25:20].
- R3: With mem_type_i = 0 (SDRAM), L is 3 + timing_i[5:4] for reads and for writes.
- R4: With mem_type_i = 1 (pipelined synchronous SRAM) or 3 (generic synchronous), L is 2 in both directions, whatever the timing word holds.
- R5: When reg_access_i is 1, L is 2 in both directions, whatever the memory type and timing word.
- R6: Type codes 4 to 7 give L = 2.
- R7: An access accepted at clock edge k raises ack_o after edge k+L+1, so a latency of zero acknowledges after the next edge.
- R8: ack_o is high for exactly one cycle per accepted access; busy_o rises at the accepting edge and falls at the edge that raises ack_o.
- R9: start_i while busy_o is high is ignored: it neither changes the running count nor produces a second acknowledge.
- R10: During and after reset, busy_o and ack_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an access (accepted only when idle) |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_access_i | input | 1 | Access targets the controller's register bank |
| mem_type_i | input | 3 | Memory type: 0 SDRAM, 1 sync SRAM, 2 async, 3 generic sync |
| timing_i | input | 32 | Timing word of the selected chip select |
| busy_o | output | 1 | Access in progress |
| ack_o | output | 1 | One-cycle completion pulse |

## Verification
Asynchronous timing words are chosen with distinct values in the read fields and the write fields, so that summing the wrong group or dropping a field gives a different cycle count; the same word is then used for both directions. SDRAM words carry ones outside bits 5:4 to show that only that field moves the count, while fixed-latency types and register accesses use all-ones words to prove the timing word is ignored. A zero asynchronous read latency and the largest read sum exercise both ends of the counter, and a second start fired mid-access shows that neither the acknowledge cycle nor the number of acknowledges changes.

// File: rtl/access_wait_pkg.sv
package access_wait_pkg;

  typedef enum logic [2:0] {
    MEM_SDRAM = 3'd0,
    MEM_PSRAM = 3'd1,
    MEM_ASYNC = 3'd2,
    MEM_GSYNC = 3'd3
  } mem_kind_e;

  // timing word field positions
  localparam int RD_A_LSB = 0;
  localparam int RD_A_MSB = 7;
  localparam int RD_B_LSB = 8;
  localparam int RD_B_MSB = 11;
  localparam int WR_A_LSB = 12;
  localparam int WR_A_MSB = 15;
  localparam int WR_B_LSB = 16;
  localparam int WR_B_MSB = 19;
  localparam int WR_C_LSB = 20;
  localparam int WR_C_MSB = 25;
  localparam int SD_LSB   = 4;
  localparam int SD_MSB   = 5;

endpackage

// File: rtl/wait_lat_calc.sv
module wait_lat_calc
  import access_wait_pkg::*;
#(
  parameter int TW         = 32,
  parameter int CW         = 10,
  parameter int REG_LAT    = 2,
  parameter int SYNC_LAT   = 2,
  parameter int OTHER_LAT  = 2,
  parameter int SDRAM_BASE = 3
) (
  input  logic          reg_access_i,
  input  logic          we_i,
  input  logic [2:0]    mem_type_i,
  input  logic [TW-1:0] timing_i,
  output logic [CW-1:0] lat_o
);

  logic [CW-1:0] async_rd, async_wr, sdram_lat;
  logic          unused_bits;

  assign unused_bits = ^{timing_i[TW-1:WR_C_MSB+1], timing_i[SD_LSB-1:0]};

  assign async_rd  = CW'(timing_i[RD_A_MSB:RD_A_LSB]) + CW'(timing_i[RD_B_MSB:RD_B_LSB]);
  assign async_wr  = CW'(timing_i[WR_A_MSB:WR_A_LSB]) + CW'(timing_i[WR_B_MSB:WR_B_LSB])
                   + CW'(timing_i[WR_C_MSB:WR_C_LSB]);
  assign sdram_lat = CW'(SDRAM_BASE) + CW'(timing_i[SD_MSB:SD_LSB]);

  always_comb begin
    if (reg_access_i) begin
      lat_o = CW'(REG_LAT);
    end else begin
      case (mem_type_i)
        MEM_ASYNC: lat_o = we_i ? async_wr : async_rd;
        MEM_SDRAM: lat_o = sdram_lat;
        MEM_PSRAM,
        MEM_GSYNC: lat_o = CW'(SYNC_LAT);
        default:   lat_o = CW'(OTHER_LAT);
      endcase
    end
  end

endmodule

// File: rtl/wait_down_counter.sv
module wait_down_counter #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] lat_i,
  output logic          busy_o,
  output logic          ack_o
);

  logic [CW-1:0] cnt_q;
  logic          busy_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          ack_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= lat_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign ack_o  = ack_q;

  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);

  // running access keeps its count whatever start_i does
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && cnt_q != '0 |=> busy_q && !ack_q);

  assert_ack_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);

  assert_ack_ends_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> !busy_q && $past(busy_q));

  assert_busy_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));

endmodule

// File: rtl/access_wait_timer.sv
module access_wait_timer
  import access_wait_pkg::*;
#(
  parameter int TW         = 32,
  parameter int CW         = 10,
  parameter int REG_LAT    = 2,
  parameter int SYNC_LAT   = 2,
  parameter int OTHER_LAT  = 2,
  parameter int SDRAM_BASE = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic          reg_access_i,
  input  logic [2:0]    mem_type_i,
  input  logic [TW-1:0] timing_i,
  output logic          busy_o,
  output logic          ack_o
);

  logic [CW-1:0] lat_w;

  wait_lat_calc #(
    .TW(TW), .CW(CW), .REG_LAT(REG_LAT), .SYNC_LAT(SYNC_LAT),
    .OTHER_LAT(OTHER_LAT), .SDRAM_BASE(SDRAM_BASE)
  ) u_calc (
    .reg_access_i (reg_access_i),
    .we_i         (we_i),
    .mem_type_i   (mem_type_i),
    .timing_i     (timing_i),
    .lat_o        (lat_w)
  );

  wait_down_counter #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .lat_i   (lat_w),
    .busy_o  (busy_o),
    .ack_o   (ack_o)
  );

  assert_reg_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_access_i |-> lat_w == CW'(REG_LAT));

  assert_sync_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_access_i && (mem_type_i == MEM_PSRAM || mem_type_i == MEM_GSYNC)
    |-> lat_w == CW'(SYNC_LAT));

  assert_other_lat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_access_i && mem_type_i[2] |-> lat_w == CW'(OTHER_LAT));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);

endmodule

// File: tb/access_wait_timer_tb.sv
module access_wait_timer_tb;

  localparam int CLK_P = 10;

  logic        clk, rst_n, start, we, reg_acc;
  logic [2:0]  mtype;
  logic [31:0] timing;
  logic        busy, ack;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  access_wait_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .we_i(we),
    .reg_access_i(reg_acc), .mem_type_i(mtype), .timing_i(timing),
    .busy_o(busy), .ack_o(ack)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int async_rd(logic [31:0] t);
    return int'(t[7:0]) + int'(t[11:8]);
  endfunction
  function automatic int async_wr(logic [31:0] t);
    return int'(t[15:12]) + int'(t[19:16]) + int'(t[25:20]);
  endfunction

  // launch one access; measure cycles to ack, check busy and pulse width
  task automatic run_access(string req, bit r, bit w, logic [2:0] ty,
                            logic [31:0] t, int exp_lat);
    int n;
    @(negedge clk);
    reg_acc = r; we = w; mtype = ty; timing = t; start = 1;
    @(negedge clk);
    start = 0;
    chk({req, " busy after start R8"}, busy, 1);
    n = 0;
    while (!ack && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " ack cycle R7"}, n, exp_lat + 1);
    chk({req, " busy low at ack R8"}, busy, 0);
    @(negedge clk);
    chk({req, " ack one cycle R8"}, ack, 0);
  endtask

  task automatic t_reset();
    chk("reset busy R10", busy, 0);
    chk("reset ack R10", ack, 0);
  endtask

  task automatic t_async();
    run_access("async rd R1", 0, 0, 3'd2, 32'h028750A3, async_rd(32'h028750A3));
    run_access("async wr R2", 0, 1, 3'd2, 32'h028750A3, async_wr(32'h028750A3));
    run_access("async rd zero R1", 0, 0, 3'd2, 32'hFFFFF000, 0);
    run_access("async rd max R1", 0, 0, 3'd2, 32'h00000FFF, 270);
    run_access("async wr max R2", 0, 1, 3'd2, 32'h03FFF000, 93);
  endtask

  task automatic t_sdram();
    run_access("sdram rd R3", 0, 0, 3'd0, 32'h00000030, 6);
    run_access("sdram wr R3", 0, 1, 3'd0, 32'h00000030, 6);
    run_access("sdram bits R3", 0, 0, 3'd0, 32'hFFFFFFCF, 3);
    run_access("sdram one R3", 0, 1, 3'd0, 32'h00000010, 4);
  endtask

  task automatic t_fixed();
    run_access("psram rd R4", 0, 0, 3'd1, 32'hFFFFFFFF, 2);
    run_access("gsync wr R4", 0, 1, 3'd3, 32'hFFFFFFFF, 2);
    run_access("reg async R5", 1, 0, 3'd2, 32'h00000FFF, 2);
    run_access("reg sdram wr R5", 1, 1, 3'd0, 32'hFFFFFFFF, 2);
    for (int ty = 4; ty < 8; ty++)
      run_access("other type R6", 0, ty[0], 3'(ty), 32'hFFFFFFFF, 2);
  endtask

  task automatic t_ignore();
    int n;
    int extra;
    @(negedge clk);
    reg_acc = 0; we = 0; mtype = 3'd2; timing = 32'h00000014; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!ack && n < 1000) begin
      @(negedge clk);
      n++;
      if (n == 3) begin
        mtype = 3'd1; timing = 32'h0; start = 1;
      end else if (n == 4) begin
        start = 0;
      end
    end
    chk("start while busy ack cycle R9", n, 21);
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ack) extra++;
    end
    chk("start while busy no second ack R9", extra, 0);
    chk("start while busy idle after R9", busy, 0);
  endtask

  initial begin
    start = 0; we = 0; reg_acc = 0; mtype = 0; timing = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_async();
    t_sdram();
    t_fixed();
    t_ignore();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule